// File: doc/BRIEF.md
# Staged Thermal Derating Controller

This block turns a set of sampled enclosure temperatures into a three-level derate stage and the per-port power restrictions that follow from it. On each valid sample it takes the hottest of the signed readings (connector, power-switch, case and inlet sensors) and compares it with three rising thresholds: warn, derate and protect. Entry into a higher stage is immediate. Exit takes one stage at a time, and only after a run of consecutive samples below that stage's threshold minus a hysteresis margin.

The stage sets the node-wide controls: burst headroom inhibit, a freeze on upward power negotiation, and slower port retries. It also sets a per-port restriction level of free, capped or off. Capping starts with high-power ports. The protect stage switches off ports not marked critical. Ports are loosened one at a time at a fixed restore interval, with low-power ports before high-power ones. The burst inhibit stays asserted until every port is free again, so burst is always cut before any floor and is the last thing given back.

Each stage change emits a one-cycle log record. The record holds the old stage, the new stage, the sensor that was hottest and a free-running timestamp. After a set number of entries into the protect stage, an inspection flag latches. From then on, non-critical ports stay off until reset.

Top module: `thermal_derate_ctrl`

## Requirements
- R1: The governing temperature is the signed maximum of all sensor readings. On a tie, the lowest sensor index is reported as the trigger.
- R2: On a valid sample the stage (0 normal, 1 warn, 2 derate, 3 protect) rises at once to the highest level whose threshold the governing temperature meets or exceeds (>=). It may skip levels.
- R3: While the stage is 1 or above, burst_inhibit, nego_freeze and retry_slow are 1. burst_inhibit also stays 1 while any port is still capped or off.
- R4: In stage 2 every high-power port reaches the capped level on the cycle after the stage register changes. Low-power ports stay free.
- R5: In stage 3 critical ports are capped and non-critical ports are off, both on the cycle after the stage register changes.
- R6: The stage falls by exactly one level after HOLD_SAMPLES consecutive valid samples strictly below (current threshold − hysteresis). Any valid sample not below that level restarts the count.
- R7: A port whose level is above its target is loosened to its target at most once per RESTORE_CYC cycles, one port at a time. Pending low-power ports are chosen before high-power ones, and within a group the lowest index goes first.
- R8: Every stage change gives a one-cycle log_valid pulse with the old stage, the new stage, the hottest sensor index, and a timestamp. The timestamp counts clock cycles since reset, so two events N cycles apart differ by N.
- R9: After INSPECT_LIMIT entries into stage 3 since reset, inspect_req latches to 1. Non-critical ports then stay off until reset.
- R10: After reset the stage is 0, all ports are free, and every control flag and log_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_valid_i | input | 1 | The readings on temps_i are a new sample |
| temps_i | input | NUM_SENS*TEMP_W | Signed readings, sensor s at bits [s*TEMP_W +: TEMP_W] |
| thr_warn_i | input | TEMP_W | Signed warn threshold |
| thr_derate_i | input | TEMP_W | Signed derate threshold |
| thr_protect_i | input | TEMP_W | Signed protect threshold |
| hyst_i | input | TEMP_W-1 | Unsigned exit hysteresis margin |
| port_high_pwr_i | input | NUM_PORTS | 1 marks a high-power port |
| port_critical_i | input | NUM_PORTS | 1 marks a critical port |
| stage_o | output | 2 | Current derate stage |
| burst_inhibit_o | output | 1 | Burst headroom withheld |
| nego_freeze_o | output | 1 | Upward power negotiation frozen |
| retry_slow_o | output | 1 | Slow port retry pacing |
| port_cap_o | output | NUM_PORTS | Port limited to its reduced cap |
| port_off_o | output | NUM_PORTS | Port powered down |
| inspect_req_o | output | 1 | Inspection required (sticky) |
| log_valid_o | output | 1 | Log record valid this cycle |
| log_from_o | output | 2 | Stage before the change |
| log_to_o | output | 2 | Stage after the change |
| log_sensor_o | output | IDX_W | Hottest sensor at the change |
| log_ts_o | output | TS_W | Timestamp of the change |

## Verification
A one-step stage drop and a port restore can occur on the same clock edge, and both must be correct on that edge. The bench provokes this by choosing a hold count equal to the restore interval and then cooling steadily from the protect stage. The restore timer then expires on the same edge where the hysteresis count completes. The bench judges the two outputs separately: the log must show 3→2, 2→1 and 1→0 in sequence, and the ports must come back in the order 0, 2, 1, 3 at exact intervals. It also counts exactly two cycles in which a log pulse and a port release coincide.

// File: rtl/thermal_derate_pkg.sv
// Shared encodings for the staged thermal derating controller.
// Assumes stage and port-level codes are ordered so larger means more restrictive.
package thermal_derate_pkg;
    localparam logic [1:0] STG_NORMAL  = 2'd0;
    localparam logic [1:0] STG_WARN    = 2'd1;
    localparam logic [1:0] STG_DERATE  = 2'd2;
    localparam logic [1:0] STG_PROTECT = 2'd3;

    localparam logic [1:0] LVL_FREE = 2'd0;
    localparam logic [1:0] LVL_CAP  = 2'd1;
    localparam logic [1:0] LVL_OFF  = 2'd2;
endpackage

// File: rtl/tdc_max_select.sv
// Picks the hottest signed reading and its sensor index.
// Assumes readings are packed side by side; ties keep the lowest index.
module tdc_max_select #(
    parameter int NUM_SENS = 4,
    parameter int TEMP_W   = 12,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_SENS*TEMP_W-1:0] temps_i,
    output logic signed [TEMP_W-1:0]   tmax_o,
    output logic [IDX_W-1:0]           idx_o
);
    // Linear scan with strict greater-than so that the first maximum wins.
    always_comb begin
        tmax_o = temps_i[TEMP_W-1:0];
        idx_o  = '0;
        for (int s = 1; s < NUM_SENS; s++) begin
            if ($signed(temps_i[s*TEMP_W +: TEMP_W]) > tmax_o) begin
                tmax_o = temps_i[s*TEMP_W +: TEMP_W];
                idx_o  = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/tdc_stage_fsm.sv
// Derate stage register with immediate rising entry, dwell-based one-step exit,
// stage-change log records, a free-running timestamp and the protect-entry count.
// Assumes the thresholds are ordered warn < derate < protect and hyst is small.
module tdc_stage_fsm
    import thermal_derate_pkg::*;
#(
    parameter int TEMP_W        = 12,
    parameter int IDX_W         = 2,
    parameter int HOLD_SAMPLES  = 64,
    parameter int INSPECT_LIMIT = 3,
    parameter int TS_W          = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_i,
    input  logic signed [TEMP_W-1:0] tmax_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic signed [TEMP_W-1:0] thr_warn_i,
    input  logic signed [TEMP_W-1:0] thr_derate_i,
    input  logic signed [TEMP_W-1:0] thr_protect_i,
    input  logic [TEMP_W-2:0]        hyst_i,
    output logic [1:0]               stage_o,
    output logic                     inspect_o,
    output logic                     log_valid_o,
    output logic [1:0]               log_from_o,
    output logic [1:0]               log_to_o,
    output logic [IDX_W-1:0]         log_sensor_o,
    output logic [TS_W-1:0]          log_ts_o
);
    localparam int HOLD_W = $clog2(HOLD_SAMPLES + 1);
    localparam int INSP_W = $clog2(INSPECT_LIMIT + 1);

    logic [1:0]               stage_q, stage_d, target_up;
    logic [HOLD_W-1:0]        dwell_q, dwell_d;
    logic [INSP_W-1:0]        insp_q;
    logic [TS_W-1:0]          ts_q;
    logic signed [TEMP_W-1:0] cur_thr;
    logic signed [TEMP_W:0]   tmax_x, exit_lvl;
    logic                     below;

    // Highest stage whose entry threshold the hottest reading meets.
    always_comb begin
        if (tmax_i >= thr_protect_i)     target_up = STG_PROTECT;
        else if (tmax_i >= thr_derate_i) target_up = STG_DERATE;
        else if (tmax_i >= thr_warn_i)   target_up = STG_WARN;
        else                             target_up = STG_NORMAL;
    end

    // Exit level of the current stage: its threshold minus the hysteresis margin.
    always_comb begin
        case (stage_q)
            STG_PROTECT: cur_thr = thr_protect_i;
            STG_DERATE:  cur_thr = thr_derate_i;
            default:     cur_thr = thr_warn_i;
        endcase
        exit_lvl = {cur_thr[TEMP_W-1], cur_thr} - $signed({2'b00, hyst_i});
        tmax_x   = {tmax_i[TEMP_W-1], tmax_i};
        below    = (stage_q != STG_NORMAL) && (tmax_x < exit_lvl);
    end

    // Next stage and dwell count, evaluated only on valid samples.
    always_comb begin
        stage_d = stage_q;
        dwell_d = dwell_q;
        if (sample_i) begin
            if (target_up > stage_q) begin
                stage_d = target_up;
                dwell_d = '0;
            end else if (below) begin
                if (dwell_q == HOLD_W'(HOLD_SAMPLES - 1)) begin
                    stage_d = stage_q - 2'd1;
                    dwell_d = '0;
                end else begin
                    dwell_d = dwell_q + 1'b1;
                end
            end else begin
                dwell_d = '0;
            end
        end
    end

    // State, timestamp, log record and protect-entry counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q      <= STG_NORMAL;
            dwell_q      <= '0;
            insp_q       <= '0;
            ts_q         <= '0;
            log_valid_o  <= 1'b0;
            log_from_o   <= STG_NORMAL;
            log_to_o     <= STG_NORMAL;
            log_sensor_o <= '0;
            log_ts_o     <= '0;
        end else begin
            stage_q     <= stage_d;
            dwell_q     <= dwell_d;
            ts_q        <= ts_q + 1'b1;
            log_valid_o <= (stage_d != stage_q);
            if (stage_d != stage_q) begin
                log_from_o   <= stage_q;
                log_to_o     <= stage_d;
                log_sensor_o <= idx_i;
                log_ts_o     <= ts_q;
            end
            if (stage_d == STG_PROTECT && stage_q != STG_PROTECT &&
                insp_q != INSP_W'(INSPECT_LIMIT))
                insp_q <= insp_q + 1'b1;
        end
    end

    assign stage_o   = stage_q;
    assign inspect_o = (insp_q == INSP_W'(INSPECT_LIMIT));

    // R6: a falling stage only ever steps down by one level.
    assert_drop_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q < $past(stage_q)) |-> (stage_q == $past(stage_q) - 2'd1));

    // R6: the dwell count never reaches the hold length.
    assert_dwell_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_q < HOLD_W'(HOLD_SAMPLES));

    // R8: one log pulse for each stage change and none otherwise.
    assert_log_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid_o == (stage_q != $past(stage_q)));

    // R9: the inspection flag never clears without reset.
    assert_inspect_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inspect_o) |-> inspect_o);
endmodule

// File: rtl/tdc_port_restrict.sv
// Per-port restriction levels (free, capped, off) that follow the derate stage.
// Tightening is immediate; loosening releases one port per restore interval,
// low-power ports first. Assumes the stage input is a registered value.
module tdc_port_restrict
    import thermal_derate_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int RESTORE_CYC = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           stage_i,
    input  logic                 inspect_i,
    input  logic [NUM_PORTS-1:0] high_pwr_i,
    input  logic [NUM_PORTS-1:0] critical_i,
    output logic [NUM_PORTS-1:0] cap_o,
    output logic [NUM_PORTS-1:0] off_o
);
    localparam int RC_W = $clog2(RESTORE_CYC + 1);

    logic [1:0]           lvl_q [NUM_PORTS];
    logic [1:0]           tgt   [NUM_PORTS];
    logic [NUM_PORTS-1:0] pend, sel, free_v;
    logic [RC_W-1:0]      rc_q;
    logic                 fire, found;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Target level of this port for the present stage and inspection state.
        always_comb begin
            if (stage_i == STG_PROTECT)
                tgt[p] = critical_i[p] ? LVL_CAP : LVL_OFF;
            else if (stage_i == STG_DERATE)
                tgt[p] = high_pwr_i[p] ? LVL_CAP : LVL_FREE;
            else
                tgt[p] = LVL_FREE;
            if (inspect_i && !critical_i[p])
                tgt[p] = LVL_OFF;
        end

        assign pend[p] = (lvl_q[p] > tgt[p]);

        // Tighten at once; loosen only when this port is released.
        always_ff @(posedge clk) begin
            if (!rst_n)                  lvl_q[p] <= LVL_FREE;
            else if (tgt[p] > lvl_q[p])  lvl_q[p] <= tgt[p];
            else if (fire && sel[p])     lvl_q[p] <= tgt[p];
        end

        assign cap_o[p] = (lvl_q[p] == LVL_CAP);
        assign off_o[p] = (lvl_q[p] == LVL_OFF);
    end

    // Release choice: first pending low-power port, else first pending port.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (!found && pend[p] && !high_pwr_i[p]) begin
                sel[p] = 1'b1;
                found  = 1'b1;
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (!found && pend[p]) begin
                sel[p] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign fire = (|pend) && (rc_q == RC_W'(RESTORE_CYC - 1));

    // Restore interval timer, running only while some port awaits release.
    always_ff @(posedge clk) begin
        if (!rst_n)      rc_q <= '0;
        else if (!(|pend) || fire) rc_q <= '0;
        else             rc_q <= rc_q + 1'b1;
    end

    assign free_v = ~cap_o & ~off_o;

    // R5: a port is only switched off while the stage was protect.
    assert_off_in_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(off_o & ~$past(off_o))) |-> ($past(stage_i) == STG_PROTECT));

    // R7: at most one port becomes free per cycle.
    assert_one_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_v & ~$past(free_v)) <= 1);
endmodule

// File: rtl/thermal_derate_ctrl.sv
// Top of the staged thermal derating controller: hottest-sensor selection,
// stage machine with logging, and per-port restriction with paced restore.
// Assumes temperatures arrive as already-sampled signed values.
module thermal_derate_ctrl
    import thermal_derate_pkg::*;
#(
    parameter int NUM_SENS      = 4,
    parameter int TEMP_W        = 12,
    parameter int NUM_PORTS     = 8,
    parameter int HOLD_SAMPLES  = 64,
    parameter int RESTORE_CYC   = 1000,
    parameter int INSPECT_LIMIT = 3,
    parameter int TS_W          = 32,
    localparam int IDX_W        = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       temp_valid_i,
    input  logic [NUM_SENS*TEMP_W-1:0] temps_i,
    input  logic signed [TEMP_W-1:0]   thr_warn_i,
    input  logic signed [TEMP_W-1:0]   thr_derate_i,
    input  logic signed [TEMP_W-1:0]   thr_protect_i,
    input  logic [TEMP_W-2:0]          hyst_i,
    input  logic [NUM_PORTS-1:0]       port_high_pwr_i,
    input  logic [NUM_PORTS-1:0]       port_critical_i,
    output logic [1:0]                 stage_o,
    output logic                       burst_inhibit_o,
    output logic                       nego_freeze_o,
    output logic                       retry_slow_o,
    output logic [NUM_PORTS-1:0]       port_cap_o,
    output logic [NUM_PORTS-1:0]       port_off_o,
    output logic                       inspect_req_o,
    output logic                       log_valid_o,
    output logic [1:0]                 log_from_o,
    output logic [1:0]                 log_to_o,
    output logic [IDX_W-1:0]           log_sensor_o,
    output logic [TS_W-1:0]            log_ts_o
);
    logic signed [TEMP_W-1:0] tmax;
    logic [IDX_W-1:0]         tidx;

    tdc_max_select #(.NUM_SENS(NUM_SENS), .TEMP_W(TEMP_W), .IDX_W(IDX_W)) u_max (
        .temps_i (temps_i),
        .tmax_o  (tmax),
        .idx_o   (tidx)
    );

    tdc_stage_fsm #(
        .TEMP_W(TEMP_W), .IDX_W(IDX_W), .HOLD_SAMPLES(HOLD_SAMPLES),
        .INSPECT_LIMIT(INSPECT_LIMIT), .TS_W(TS_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (temp_valid_i),
        .tmax_i        (tmax),
        .idx_i         (tidx),
        .thr_warn_i    (thr_warn_i),
        .thr_derate_i  (thr_derate_i),
        .thr_protect_i (thr_protect_i),
        .hyst_i        (hyst_i),
        .stage_o       (stage_o),
        .inspect_o     (inspect_req_o),
        .log_valid_o   (log_valid_o),
        .log_from_o    (log_from_o),
        .log_to_o      (log_to_o),
        .log_sensor_o  (log_sensor_o),
        .log_ts_o      (log_ts_o)
    );

    tdc_port_restrict #(.NUM_PORTS(NUM_PORTS), .RESTORE_CYC(RESTORE_CYC)) u_ports (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_i    (stage_o),
        .inspect_i  (inspect_req_o),
        .high_pwr_i (port_high_pwr_i),
        .critical_i (port_critical_i),
        .cap_o      (port_cap_o),
        .off_o      (port_off_o)
    );

    // Node-wide controls; burst stays withheld until every port is free again.
    assign nego_freeze_o   = (stage_o != STG_NORMAL);
    assign retry_slow_o    = (stage_o != STG_NORMAL);
    assign burst_inhibit_o = (stage_o != STG_NORMAL) || (|port_cap_o) || (|port_off_o);

    // R3: burst was already withheld the cycle before any port gets capped.
    assert_burst_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(port_cap_o & ~$past(port_cap_o))) |-> $past(burst_inhibit_o));
endmodule

// File: tb/thermal_derate_ctrl_tb_top.sv
`timescale 1ns/1ps
module thermal_derate_ctrl_tb_top;
    localparam int NS = 4, TW = 12, NP = 4, HOLD = 3, RST_CYC = 3, INSP = 2, TSW = 16;
    localparam logic [NP-1:0] HIGH = 4'b1010, CRIT = 4'b0011;

    logic clk = 1'b0, rst_n = 1'b0, tvalid = 1'b0;
    logic [NS*TW-1:0] temps = '0;
    logic [1:0] stage, lfrom, lto, lsens;
    logic burst, nego, retry, insp, lvalid;
    logic [NP-1:0] cap, off;
    logic [TSW-1:0] lts;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    thermal_derate_ctrl #(
        .NUM_SENS(NS), .TEMP_W(TW), .NUM_PORTS(NP), .HOLD_SAMPLES(HOLD),
        .RESTORE_CYC(RST_CYC), .INSPECT_LIMIT(INSP), .TS_W(TSW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_valid_i(tvalid), .temps_i(temps),
        .thr_warn_i(12'sd40), .thr_derate_i(12'sd60), .thr_protect_i(12'sd80),
        .hyst_i(11'd5), .port_high_pwr_i(HIGH), .port_critical_i(CRIT),
        .stage_o(stage), .burst_inhibit_o(burst), .nego_freeze_o(nego),
        .retry_slow_o(retry), .port_cap_o(cap), .port_off_o(off),
        .inspect_req_o(insp), .log_valid_o(lvalid), .log_from_o(lfrom),
        .log_to_o(lto), .log_sensor_o(lsens), .log_ts_o(lts)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_stage(input int v);
        return (v >= 80) ? 3 : (v >= 60) ? 2 : (v >= 40) ? 1 : 0;
    endfunction

    task automatic set_temps(input int a, input int b, input int c, input int d);
        temps = {TW'(d), TW'(c), TW'(b), TW'(a)};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tvalid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One valid sample; returns at the negedge after the edge that took it.
    task automatic sample1(input int a, input int b, input int c, input int d);
        set_temps(a, b, c, d);
        tvalid = 1'b1;
        @(negedge clk);
        tvalid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ts1;
        do_reset();
        // R10 reset state
        chk("R10 stage", stage, 0);
        chk("R10 flags", {burst, nego, retry, insp, lvalid}, 0);
        chk("R10 ports", {cap, off}, 0);

        // R1/R2/R3/R4/R5 sweep: each sensor hottest, across and on the thresholds
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < 15; i++) begin
                int v, e;
                int t[4];
                v = -40 + 10 * i;
                e = exp_stage(v);
                t = '{-60, -60, -60, -60};
                t[s] = v;
                do_reset();
                sample1(t[0], t[1], t[2], t[3]);
                chk("R2 stage", stage, e);
                chk("R8 log pulse", lvalid, (e != 0) ? 1 : 0);
                if (e != 0) begin
                    chk("R1 sensor idx", lsens, s);
                    chk("R8 from", lfrom, 0);
                    chk("R8 to", lto, e);
                end
                chk("R3 flags", {burst, nego, retry}, (e != 0) ? 7 : 0);
                @(negedge clk);
                chk("R4 caps", cap, (e == 3) ? int'(CRIT) : (e == 2) ? int'(HIGH) : 0);
                chk("R5 offs", off, (e == 3) ? int'(~CRIT & 4'hF) : 0);
            end
        end

        // R1 ties: lowest index wins
        do_reset();
        sample1(65, 65, 65, 65);
        chk("R1 tie all", lsens, 0);
        do_reset();
        sample1(0, 10, 70, 70);
        chk("R1 tie 2v3", lsens, 2);

        // R8 timestamp spacing
        do_reset();
        sample1(45, 0, 0, 0);
        ts1 = int'(lts);
        repeat (7) @(negedge clk);
        sample1(65, 0, 0, 0);
        chk("R8 ts delta", int'(lts) - ts1, 8);
        chk("R8 from 1", lfrom, 1);
        chk("R8 to 2", lto, 2);

        // R6 hysteresis: inside margin holds, interrupted dwell restarts
        for (int k = 0; k < 5; k++) begin
            sample1(57, 0, 0, 0);
            chk("R6 inside margin", stage, 2);
            chk("R6 no log", lvalid, 0);
        end
        sample1(54, 0, 0, 0); chk("R6 dwell1", stage, 2);
        sample1(54, 0, 0, 0); chk("R6 dwell2", stage, 2);
        sample1(57, 0, 0, 0); chk("R6 interrupt", stage, 2);
        sample1(54, 0, 0, 0); chk("R6 restart1", stage, 2);
        sample1(54, 0, 0, 0); chk("R6 restart2", stage, 2);
        sample1(54, 0, 0, 0); chk("R6 drop", stage, 1);
        chk("R8 drop log", {lvalid, lfrom, lto}, {1'b1, 2'd2, 2'd1});
        for (int k = 0; k < 4; k++) begin
            sample1(36, 0, 0, 0);
            chk("R6 warn holds", stage, 1);
        end
        for (int k = 0; k < 3; k++) sample1(34, 0, 0, 0);
        chk("R6 to normal", stage, 0);

        // R2 jump 0->3 then R7 paced restore alongside stage drops
        do_reset();
        sample1(85, 0, 0, 0);
        chk("R2 jump", {lfrom, lto}, {2'd0, 2'd3});
        chk("R9 one entry", insp, 0);
        @(negedge clk);
        chk("R5 caps", cap, CRIT);
        chk("R5 offs", off, ~CRIT & 4'hF);
        begin
            int order[4];
            int n_ev, last_c, n_log, coinc, idx;
            logic [NP-1:0] prev_free, fv, newly;
            n_ev = 0; last_c = 0; n_log = 0; coinc = 0;
            idx = 0;
            for (int p = 0; p < NP; p++) if (!HIGH[p]) begin order[idx] = p; idx++; end
            for (int p = 0; p < NP; p++) if (HIGH[p]) begin order[idx] = p; idx++; end
            set_temps(30, 30, 30, 30);
            tvalid = 1'b1;
            prev_free = ~(cap | off);
            for (int c = 1; c <= 20; c++) begin
                @(negedge clk);
                fv = ~(cap | off);
                newly = fv & ~prev_free;
                if (newly != 0) begin
                    chk("R7 one port", $countones(newly), 1);
                    idx = 0;
                    for (int p = 0; p < NP; p++) if (newly[p]) idx = p;
                    if (n_ev < 4) chk("R7 order", idx, order[n_ev]);
                    if (n_ev > 0) chk("R7 interval", c - last_c, RST_CYC);
                    chk("R3 burst until free", burst, (n_ev < 3) ? 1 : 0);
                    last_c = c;
                    n_ev++;
                end
                if (lvalid) begin
                    chk("R8 desc from", lfrom, 3 - n_log);
                    chk("R8 desc to", lto, 2 - n_log);
                    n_log++;
                    if (newly != 0) coinc++;
                end
                prev_free = fv;
            end
            tvalid = 1'b0;
            chk("R7 releases", n_ev, 4);
            chk("R8 descent logs", n_log, 3);
            chk("R7 same-cycle drops", coinc, 2);
            chk("R3 all clear", {stage, burst, nego, retry}, 0);
        end

        // R9 second protect entry latches inspection; non-critical stay off
        sample1(85, 0, 0, 0);
        chk("R9 latched", insp, 1);
        set_temps(30, 30, 30, 30);
        tvalid = 1'b1;
        repeat (30) @(negedge clk);
        tvalid = 1'b0;
        chk("R9 stage back", stage, 0);
        chk("R9 kept off", off, ~CRIT & 4'hF);
        chk("R9 critical free", cap, 0);
        chk("R9 still latched", insp, 1);
        chk("R3 burst held", burst, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule